// File: doc/BRIEF.md
# Accumulator with Per-Bit Function Multiplexer

This block is the working register of a small processor datapath. It holds an accumulator word and a separate one-bit carry flag. A 3-bit function code arrives on every clock. On each rising edge it chooses what the accumulator takes next:

- its own present value;
- an operand word;
- a bitwise combination of the accumulator and the operand;
- the sum from an adder;
- zero.

Every accumulator bit is built as one flip-flop fed by an eight-input multiplexer. Holding is just one more multiplexer input that feeds the bit's own value back. There is no separate enable. The carry flag is built the same way and changes only when the add code is chosen.

A sequencer outside the block drives the function code, the operand and the carry-in. To do multi-word additions with a chained carry, the sequencer routes the carry flag back to the carry-in between adds. The accumulator width and the adder implementation are parameters.

Top module: `accum_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator and the carry flag both become zero on that edge (synchronous, active high).
- R2: Code 3'b000 (hold) leaves both the accumulator and the carry flag unchanged.
- R3: Code 3'b001 loads the operand into the accumulator.
- R4: Code 3'b010 loads the bitwise complement of the accumulator.
- R5: Code 3'b011 loads accumulator AND operand, and code 3'b100 loads accumulator OR operand.
- R6: Code 3'b101 loads accumulator XOR operand.
- R7: Code 3'b110 loads (accumulator + operand + carry_in) modulo 2^WIDTH.
- R8: Under code 3'b110 the carry flag takes the adder carry-out, which is 1 exactly when the full sum reaches 2^WIDTH. Under every other code the carry flag keeps its value.
- R9: Code 3'b111 clears the accumulator to zero.
- R10: Consecutive add codes, with carry_in taken from the carry flag, produce the same result as a single wide addition carried out one word at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| func_sel | input | 3 | Function code picking the multiplexer input for every bit |
| operand | input | WIDTH | Second operand word |
| carry_in | input | 1 | Carry into the least significant adder stage |
| acc_q | output | WIDTH | Accumulator value |
| carry_q | output | 1 | Carry flag value |

## Verification
The bench builds the block with its defaults: an 8-bit word and the explicit ripple-carry adder. The word is narrow, so random operands hit the modulo-256 wrap and the carry-out often. That lets carry chaining over consecutive adds and the flag's hold behaviour under all seven non-add codes be checked many times. Directed cases add the extremes: an all-ones word plus one, a zero sum with carry-in, and a reset applied from a nonzero state.

// File: rtl/accum_pkg.sv
package accum_pkg;
   localparam int FN_BITS = 3;

   typedef enum logic [FN_BITS-1:0] {
      FN_HOLD = 3'b000,
      FN_LOAD = 3'b001,
      FN_INV  = 3'b010,
      FN_AND  = 3'b011,
      FN_OR   = 3'b100,
      FN_XOR  = 3'b101,
      FN_ADD  = 3'b110,
      FN_CLR  = 3'b111
   } acc_fn_e;

   localparam int ADDER_RIPPLE = 0;
   localparam int ADDER_INFER  = 1;
endpackage

// File: rtl/accum_adder.sv
module accum_adder #(
   parameter int WIDTH = 8,
   parameter int STYLE = accum_pkg::ADDER_RIPPLE
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   if (WIDTH < 1) begin : g_bad_width
      $error("accum_adder: WIDTH must be at least 1");
   end
   if (STYLE != accum_pkg::ADDER_RIPPLE && STYLE != accum_pkg::ADDER_INFER) begin : g_bad_style
      $error("accum_adder: unknown STYLE");
   end

   if (STYLE == accum_pkg::ADDER_RIPPLE) begin : g_ripple
      logic [WIDTH:0] chain;
      assign chain[0] = cin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_fa
         assign sum[i]     = a[i] ^ b[i] ^ chain[i];
         assign chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
      end
      assign cout = chain[WIDTH];
   end else begin : g_infer
      logic [WIDTH:0] wide;
      assign wide = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
      assign sum  = wide[WIDTH-1:0];
      assign cout = wide[WIDTH];
   end
endmodule

// File: rtl/accum_bit_slice.sv
module accum_bit_slice
   import accum_pkg::*;
(
   input  logic               clk,
   input  logic               rst,
   input  logic [FN_BITS-1:0] sel,
   input  logic               opr_bit,
   input  logic               sum_bit,
   output logic               q
);
   logic d;

   always_comb begin
      unique case (acc_fn_e'(sel))
         FN_HOLD: d = q;
         FN_LOAD: d = opr_bit;
         FN_INV:  d = ~q;
         FN_AND:  d = q & opr_bit;
         FN_OR:   d = q | opr_bit;
         FN_XOR:  d = q ^ opr_bit;
         FN_ADD:  d = sum_bit;
         FN_CLR:  d = 1'b0;
         default: d = q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= d;
   end

   a_r2_bit_hold: assert property (@(posedge clk) disable iff (rst)
      (sel == FN_HOLD) |=> $stable(q));
   a_r9_bit_clear: assert property (@(posedge clk) disable iff (rst)
      (sel == FN_CLR) |=> (q == 1'b0));
endmodule

// File: rtl/accum_carry_cell.sv
module accum_carry_cell
   import accum_pkg::*;
(
   input  logic               clk,
   input  logic               rst,
   input  logic [FN_BITS-1:0] sel,
   input  logic               add_cout,
   output logic               q
);
   logic d;

   always_comb begin
      unique case (acc_fn_e'(sel))
         FN_ADD:  d = add_cout;
         FN_HOLD, FN_LOAD, FN_INV, FN_AND,
         FN_OR,   FN_XOR,  FN_CLR: d = q;
         default: d = q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= d;
   end

   a_r8_carry_keep: assert property (@(posedge clk) disable iff (rst)
      (sel != FN_ADD) |=> $stable(q));
endmodule

// File: rtl/accum_unit.sv
module accum_unit
   import accum_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int ADDER_STYLE = ADDER_RIPPLE
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [FN_BITS-1:0] func_sel,
   input  logic [WIDTH-1:0]   operand,
   input  logic               carry_in,
   output logic [WIDTH-1:0]   acc_q,
   output logic               carry_q
);
   localparam int FULL_W = WIDTH + 1;

   if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
      $error("accum_unit: WIDTH must lie in 1..64");
   end

   logic [WIDTH-1:0] sum_w;
   logic             cout_w;

   accum_adder #(.WIDTH(WIDTH), .STYLE(ADDER_STYLE)) u_adder (
      .a    (acc_q),
      .b    (operand),
      .cin  (carry_in),
      .sum  (sum_w),
      .cout (cout_w)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      accum_bit_slice u_slice (
         .clk     (clk),
         .rst     (rst),
         .sel     (func_sel),
         .opr_bit (operand[i]),
         .sum_bit (sum_w[i]),
         .q       (acc_q[i])
      );
   end

   accum_carry_cell u_carry (
      .clk      (clk),
      .rst      (rst),
      .sel      (func_sel),
      .add_cout (cout_w),
      .q        (carry_q)
   );

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (acc_q == '0 && carry_q == 1'b0));
   a_r2_hold_all: assert property (@(posedge clk) disable iff (rst)
      (func_sel == FN_HOLD) |=> ($stable(acc_q) && $stable(carry_q)));
   a_r3_load: assert property (@(posedge clk) disable iff (rst)
      (func_sel == FN_LOAD) |=> (acc_q == $past(operand)));
   a_r4_invert: assert property (@(posedge clk) disable iff (rst)
      (func_sel == FN_INV) |=> (acc_q == ~$past(acc_q)));
   a_r5_and: assert property (@(posedge clk) disable iff (rst)
      (func_sel == FN_AND) |=> (acc_q == ($past(acc_q) & $past(operand))));
   a_r5_or: assert property (@(posedge clk) disable iff (rst)
      (func_sel == FN_OR) |=> (acc_q == ($past(acc_q) | $past(operand))));
   a_r6_xor: assert property (@(posedge clk) disable iff (rst)
      (func_sel == FN_XOR) |=> (acc_q == ($past(acc_q) ^ $past(operand))));
   a_r7_add_sum: assert property (@(posedge clk) disable iff (rst)
      (func_sel == FN_ADD) |=>
         ({carry_q, acc_q} == FULL_W'({1'b0, $past(acc_q)} + {1'b0, $past(operand)}
                                     + FULL_W'($past(carry_in)))));
   a_r9_clear: assert property (@(posedge clk) disable iff (rst)
      (func_sel == FN_CLR) |=> (acc_q == '0));
endmodule

// File: tb/tb_accum_unit.sv
module tb_accum_unit;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;
   localparam int RAND_OPS   = 600;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [2:0]   func_sel = 3'b000;
   logic [W-1:0] operand = '0;
   logic         carry_in = 1'b0;
   logic [W-1:0] acc_q;
   logic         carry_q;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] m_acc = '0;
   logic         m_c   = 1'b0;
   bit           done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   accum_unit #(.WIDTH(W)) dut (
      .clk(clk), .rst(rst), .func_sel(func_sel), .operand(operand),
      .carry_in(carry_in), .acc_q(acc_q), .carry_q(carry_q)
   );

   function automatic string req_of(input logic [2:0] f);
      case (f)
         3'b000: return "R2";
         3'b001: return "R3";
         3'b010: return "R4";
         3'b011, 3'b100: return "R5";
         3'b101: return "R6";
         3'b110: return "R7";
         default: return "R9";
      endcase
   endfunction

   function automatic logic [W:0] next_state(input logic [W-1:0] a, input logic c,
                                             input logic [2:0] f, input logic [W-1:0] b,
                                             input logic ci);
      logic [W:0] s;
      s = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
      case (f)
         3'b000: return {c, a};
         3'b001: return {c, b};
         3'b010: return {c, ~a};
         3'b011: return {c, a & b};
         3'b100: return {c, a | b};
         3'b101: return {c, a ^ b};
         3'b110: return s;
         default: return {c, {W{1'b0}}};
      endcase
   endfunction

   task automatic check(input string req, input logic [W-1:0] ea, input logic ec);
      checks++;
      if (acc_q !== ea || carry_q !== ec) begin
         errors++;
         $display("FAIL %s: acc=%02h carry=%b expected acc=%02h carry=%b",
                  req, acc_q, carry_q, ea, ec);
      end
   endtask

   task automatic step(input logic [2:0] f, input logic [W-1:0] b, input logic ci);
      logic [W:0] nx;
      @(negedge clk);
      func_sel = f; operand = b; carry_in = ci; rst = 1'b0;
      nx = next_state(m_acc, m_c, f, b, ci);
      @(posedge clk); #1;
      m_acc = nx[W-1:0]; m_c = nx[W];
      check(req_of(f), m_acc, m_c);
      if (f != 3'b110) check("R8", m_acc, m_c);
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1; func_sel = 3'b001; operand = 8'hA5;
      @(posedge clk); #1;
      m_acc = '0; m_c = 1'b0;
      check("R1", m_acc, m_c);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: acc=%02h carry=%b expected completion", acc_q, carry_q);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      do_reset();
      // R1 from a nonzero state, carry set
      step(3'b001, 8'hFF, 1'b0);
      step(3'b110, 8'h01, 1'b0);   // R8: FF+01 -> 00, carry 1
      check("R8", 8'h00, 1'b1);
      do_reset();
      step(3'b110, 8'h00, 1'b1);   // R7: zero plus carry-in
      check("R7", 8'h01, 1'b0);
      step(3'b000, 8'h5A, 1'b1);   // R2
      step(3'b010, 8'h00, 1'b0);   // R4
      step(3'b111, 8'hFF, 1'b1);   // R9
      // R10: 32-bit addition done as four chained 8-bit adds
      begin
         logic [31:0] x, y, z, got;
         x = $urandom; y = $urandom; z = x + y;
         for (int k = 0; k < 4; k++) begin
            step(3'b001, x[8*k +: 8], 1'b0);
            step(3'b110, y[8*k +: 8], (k == 0) ? 1'b0 : m_c);
            got[8*k +: 8] = acc_q;
         end
         checks++;
         if (got !== z) begin
            errors++;
            $display("FAIL R10: sum=%08h expected=%08h", got, z);
         end
      end
      for (int n = 0; n < RAND_OPS; n++) begin
         logic [2:0] f;
         f = 3'($urandom % 8);
         if (n % 50 == 49) do_reset();
         step(f, W'($urandom), (f == 3'b110 && ($urandom % 2) == 0) ? m_c : 1'($urandom));
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule